// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Interface

This block sits on the slave side of a microcontroller-style bus in which the low address byte and the data byte share one set of eight wires. An address latch strobe marks when the shared wires carry the low address. Eight dedicated inputs carry the high address byte. A chip enable, a program-fetch read strobe, a general read strobe and a write strobe complete the bus. The block captures the 16-bit address and decides whether the access belongs to this device. It then classifies the strobe pattern as a memory fetch, a memory-or-register read, or a write.

Toward the inside of the chip it issues a one-cycle read request with the address and a register-space flag. The downstream memory or register block answers on `rd_data`, and the interface returns that value to the bus. A completed write appears as a one-cycle pulse carrying the address and the captured data byte. The shared pads are modelled as a data-out value plus an output enable.

All bus inputs are asynchronous. They pass through a two-flop synchronizer, and edges are detected on the synchronized copies. A change on a strobe therefore shows up at the registered outputs on the third rising clock edge after it.

Top module: `mbus_slave_if`

## Requirements
- R1: On a high-to-low transition of `ale`, the block captures the address `{a_hi, ad_in}`. That value appears on `rd_addr` or `wr_addr` for the access that follows.
- R2: `ce_n` is sampled only at the `ale` falling edge. If it was high there, the access that follows produces no `rd_req`, no `wr_pulse` and no `ad_oe`.
- R3: A fetch is `psen_n` low with `rd_n` and `wr_n` high. On a selected fetch the block pulses `rd_req` with `rd_is_reg` = 0 and the latched address.
- R4: A general read is `rd_n` low with `psen_n` and `wr_n` high. On a selected general read the block pulses `rd_req`. `rd_is_reg` is 1 exactly when the latched upper byte equals parameter `REG_PAGE` (default 8'hFF), and 0 otherwise.
- R5: `ad_oe` is low until a legal read strobe has been seen low. While `ad_oe` is high, `ad_out` equals `rd_data`. While `ad_oe` is low, `ad_out` is 0.
- R6: `ad_oe` returns low once the active read strobe returns high.
- R7: A write is `wr_n` low with `rd_n` and `psen_n` high. When a selected write ends by `wr_n` rising back to all-strobes-high, the block pulses `wr_pulse` once. The pulse carries the latched address and the byte present on `ad_in` at that rise.
- R8: Any other strobe pattern (two or more strobes low) is ignored and keeps `ad_oe` low. A write whose pattern turns illegal before `wr_n` rises is dropped without a `wr_pulse`.
- R9: `standby` is 1 exactly when the synchronized `ce_n` is high and the synchronized `ale` is low.
- R10: During reset, `rd_req`, `wr_pulse`, `ad_oe`, `ad_out` and `rd_addr` are all 0.
- R11: `rd_req` and `wr_pulse` are high for one clock cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address latch enable; falling edge captures the address |
| ce_n | input | 1 | Active-low chip enable |
| psen_n | input | 1 | Active-low program-fetch read strobe |
| rd_n | input | 1 | Active-low general read strobe |
| wr_n | input | 1 | Active-low write strobe |
| a_hi | input | 8 | High address byte |
| ad_in | input | 8 | Shared bus, pad input side |
| ad_out | output | 8 | Shared bus, pad output value |
| ad_oe | output | 1 | Shared bus pad output enable |
| rd_req | output | 1 | One-cycle read request |
| rd_is_reg | output | 1 | Read targets register space |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data returned by the downstream block |
| wr_pulse | output | 1 | One-cycle write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| standby | output | 1 | Interface is deselected and idle |

## Verification
The assertions assume that the bus master holds the address on `a_hi` and `ad_in` for at least three clock cycles after `ale` falls. They also assume that write data is held for three cycles after `wr_n` rises, and that `ce_n` stays steady for the whole access. The stimulus meets these assumptions by changing inputs only on falling clock edges and holding every level for four or more cycles. Addresses, selects and operation types are drawn at random from a fixed seed. Directed cases cover a deselected access, an illegal two-strobe pattern and a write spoiled midway by a read strobe.

// File: rtl/mbus_pkg.sv
// Package: shared bus command type and the strobe-pattern decoder.
// Assumes strobes are active low and already synchronized.
package mbus_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_FETCH,
        CMD_READ,
        CMD_WRITE,
        CMD_BAD
    } bus_cmd_e;

    // Map the three strobe levels onto one command.
    function automatic bus_cmd_e decode_cmd(input logic psen_n, input logic rd_n, input logic wr_n);
        case ({psen_n, rd_n, wr_n})
            3'b111:  return CMD_IDLE;
            3'b011:  return CMD_FETCH;
            3'b101:  return CMD_READ;
            3'b110:  return CMD_WRITE;
            default: return CMD_BAD;
        endcase
    endfunction

endpackage

// File: rtl/mbus_sync.sv
// Module: multi-bit flop-chain synchronizer.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module mbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
// Module: captures the full address and the device select on the latch strobe's
// falling edge. Assumes the raw address pins stay stable until the edge is seen
// through the synchronizer.
module mbus_addr_latch #(
    parameter int HI_W = 8,
    parameter int LO_W = 8,
    localparam int ADDR_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_s,
    input  logic              ce_n_s,
    input  logic [HI_W-1:0]   a_hi,
    input  logic [LO_W-1:0]   ad_lo,
    output logic [ADDR_W-1:0] addr_q,
    output logic              sel_q
);
    logic ale_prev;
    logic ale_fall;

    assign ale_fall = ale_prev & ~ale_s;

    // Remember the last synchronized latch strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) ale_prev <= 1'b0;
        else        ale_prev <= ale_s;
    end

    // On the falling edge, grab the address and judge the device select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q  <= 1'b0;
        end else if (ale_fall) begin
            addr_q <= {a_hi, ad_lo};
            sel_q  <= ~ce_n_s;
        end
    end
endmodule

// File: rtl/mbus_ctrl.sv
// Module: tracks the strobe command, raises read requests and write pulses,
// and owns the pad output enable. Assumes cmd comes from synchronized strobes
// and that write data is still on the pins when the write ends.
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int              HI_W     = 8,
    parameter int              LO_W     = 8,
    parameter logic [HI_W-1:0] REG_PAGE = '1,
    localparam int ADDR_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_e          cmd,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LO_W-1:0]   ad_lo,
    output logic              rd_req,
    output logic              rd_is_reg,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LO_W-1:0]   wr_data,
    output logic              oe
);
    bus_cmd_e cmd_prev;
    bus_cmd_e rd_kind;
    logic     rd_act;
    logic     wr_armed;
    logic     rd_start;
    logic     wr_start;

    assign rd_start = sel && (cmd_prev == CMD_IDLE) && (cmd == CMD_FETCH || cmd == CMD_READ);
    assign wr_start = sel && (cmd_prev == CMD_IDLE) && (cmd == CMD_WRITE);
    assign oe       = rd_act && (cmd == rd_kind);

    // Keep the previous command for edge decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_prev <= CMD_IDLE;
        else        cmd_prev <= cmd;
    end

    // Issue a read request and hold the read active while its strobe stays low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req    <= 1'b0;
            rd_is_reg <= 1'b0;
            rd_addr   <= '0;
            rd_kind   <= CMD_IDLE;
            rd_act    <= 1'b0;
        end else begin
            rd_req <= 1'b0;
            if (rd_start) begin
                rd_req    <= 1'b1;
                rd_addr   <= addr;
                rd_is_reg <= (cmd == CMD_READ) && (addr[ADDR_W-1 -: HI_W] == REG_PAGE);
                rd_kind   <= cmd;
                rd_act    <= 1'b1;
            end else if (rd_act && cmd != rd_kind) begin
                rd_act <= 1'b0;
            end
        end
    end

    // Arm on a clean write start, fire when it ends cleanly, drop it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_armed <= 1'b0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_pulse <= 1'b0;
            if (wr_start) begin
                wr_armed <= 1'b1;
            end else if (wr_armed && cmd == CMD_IDLE) begin
                wr_armed <= 1'b0;
                wr_pulse <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= ad_lo;
            end else if (wr_armed && cmd != CMD_WRITE) begin
                wr_armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mbus_slave_if.sv
// Module: top of the multiplexed bus slave. Synchronizes the bus controls,
// latches the address, decodes the access and models the shared pads.
// Assumes a single bus master and an internal clock well above the strobe rate.
module mbus_slave_if
    import mbus_pkg::*;
#(
    parameter int                HI_W        = 8,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [HI_W-1:0]   REG_PAGE    = '1,
    localparam int ADDR_W = HI_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              ce_n,
    input  logic              psen_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [HI_W-1:0]   a_hi,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rd_req,
    output logic              rd_is_reg,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              standby
);
    logic [4:0]        ctl_s;
    logic              ale_s, ce_n_s, psen_s, rd_s, wr_s;
    logic [ADDR_W-1:0] addr_q;
    logic              sel_q;
    bus_cmd_e          cmd;

    mbus_sync #(
        .W       (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b01111)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ale, ce_n, psen_n, rd_n, wr_n}),
        .q     (ctl_s)
    );

    assign {ale_s, ce_n_s, psen_s, rd_s, wr_s} = ctl_s;
    assign cmd     = decode_cmd(psen_s, rd_s, wr_s);
    assign standby = ce_n_s & ~ale_s;

    mbus_addr_latch #(
        .HI_W (HI_W),
        .LO_W (DATA_W)
    ) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale_s  (ale_s),
        .ce_n_s (ce_n_s),
        .a_hi   (a_hi),
        .ad_lo  (ad_in),
        .addr_q (addr_q),
        .sel_q  (sel_q)
    );

    mbus_ctrl #(
        .HI_W     (HI_W),
        .LO_W     (DATA_W),
        .REG_PAGE (REG_PAGE)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .sel       (sel_q),
        .addr      (addr_q),
        .ad_lo     (ad_in),
        .rd_req    (rd_req),
        .rd_is_reg (rd_is_reg),
        .rd_addr   (rd_addr),
        .wr_pulse  (wr_pulse),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .oe        (ad_oe)
    );

    assign ad_out = ad_oe ? rd_data : '0;
endmodule

// File: rtl/mbus_slave_if_chk.sv
// Module: property checker for the bus slave, attached by bind.
// Assumes the reset is synchronous and active low.
module mbus_slave_if_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              wr_pulse,
    input logic              ad_oe,
    input logic [ADDR_W-1:0] rd_addr
);
    AST_RD_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R11
    AST_WR_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R11
    AST_OE_OPENS_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> rd_req); // R5
    AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && $past(ad_oe)) |-> $stable(rd_addr)); // R1
    AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !ad_oe); // R8
endmodule

bind mbus_slave_if mbus_slave_if_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_pulse (wr_pulse),
    .ad_oe    (ad_oe),
    .rd_addr  (rd_addr)
);

// File: tb/mbus_slave_if_tb_top.sv
module mbus_slave_if_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0, ce_n = 1'b1, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  a_hi = '0, ad_in = '0;
    logic [7:0]  ad_out, rd_data, wr_data;
    logic        ad_oe, rd_req, rd_is_reg, wr_pulse, standby;
    logic [15:0] rd_addr, wr_addr;

    int n_vec = 0, n_bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_slave_if dut_i (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ce_n(ce_n), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .a_hi(a_hi), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .rd_req(rd_req), .rd_is_reg(rd_is_reg), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
        .wr_data(wr_data), .standby(standby)
    );

    // Downstream responder model.
    function automatic logic [7:0] resp(input logic [15:0] a, input logic is_reg);
        return a[15:8] ^ a[7:0] ^ (is_reg ? 8'hA5 : 8'h00);
    endfunction
    assign rd_data = resp(rd_addr, rd_is_reg);

    function automatic logic exp_reg(input logic [15:0] a);
        return a[15:8] == 8'hFF;
    endfunction

    // Count request and pulse cycles after the edge has settled.
    always @(posedge clk) begin
        #1;
        if (rd_req)   rd_cnt++;
        if (wr_pulse) wr_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic latch_addr(input logic [15:0] a, input bit sel);
        @(negedge clk);
        a_hi = a[15:8]; ad_in = a[7:0]; ce_n = !sel; ale = 1'b1;
        repeat (4) @(negedge clk);
        ale = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 standby", standby, !sel);
        rd_cnt = 0; wr_cnt = 0;
    endtask

    // op: 0 fetch, 1 read, 2 write, 3 illegal, 4 spoiled write
    task automatic access(input logic [15:0] a, input bit sel, input int op, input logic [7:0] d);
        logic isr;
        latch_addr(a, sel);
        chk("R5 oe idle", ad_oe, 1'b0);
        case (op)
            0, 1: begin
                isr = (op == 1) && exp_reg(a);
                if (op == 0) psen_n = 1'b0; else rd_n = 1'b0;
                repeat (6) @(negedge clk);
                chk(sel ? (op == 0 ? "R3 req" : "R4 req") : "R2 req", rd_cnt, sel);
                chk("R5 oe", ad_oe, sel);
                chk("R5 ad_out", ad_out, sel ? resp(a, isr) : 8'h00);
                if (sel) begin
                    chk("R1 rd_addr", rd_addr, a);
                    chk(op == 0 ? "R3 space" : "R4 space", rd_is_reg, isr);
                end
                psen_n = 1'b1; rd_n = 1'b1;
                repeat (4) @(negedge clk);
                chk("R6 oe off", ad_oe, 1'b0);
                chk("R11 req once", rd_cnt, sel);
                chk("R8 no wr on read", wr_cnt, 0);
            end
            2: begin
                ad_in = d; wr_n = 1'b0;
                repeat (4) @(negedge clk);
                wr_n = 1'b1;
                repeat (5) @(negedge clk);
                chk(sel ? "R7 pulse" : "R2 pulse", wr_cnt, sel);
                if (sel) begin
                    chk("R7 wr_addr", wr_addr, a);
                    chk("R7 wr_data", wr_data, d);
                end
                chk("R8 no oe on write", ad_oe, 1'b0);
                chk("R8 no rd on write", rd_cnt, 0);
            end
            3: begin
                rd_n = 1'b0; wr_n = 1'b0;
                repeat (5) @(negedge clk);
                chk("R8 illegal oe", ad_oe, 1'b0);
                rd_n = 1'b1; wr_n = 1'b1;
                repeat (5) @(negedge clk);
                chk("R8 illegal rd", rd_cnt, 0);
                chk("R8 illegal wr", wr_cnt, 0);
            end
            default: begin
                ad_in = d; wr_n = 1'b0;
                repeat (4) @(negedge clk);
                psen_n = 1'b0;
                repeat (4) @(negedge clk);
                chk("R8 spoil oe", ad_oe, 1'b0);
                psen_n = 1'b1; wr_n = 1'b1;
                repeat (5) @(negedge clk);
                chk("R8 spoiled write", wr_cnt, 0);
                chk("R8 spoil rd", rd_cnt, 0);
            end
        endcase
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        chk("R10 rd_req", rd_req, 0);
        chk("R10 wr_pulse", wr_pulse, 0);
        chk("R10 ad_oe", ad_oe, 0);
        chk("R10 ad_out", ad_out, 0);
        chk("R10 rd_addr", rd_addr, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        access(16'h1234, 1, 0, 8'h00);
        access(16'hFF07, 1, 1, 8'h00);
        access(16'h3C07, 1, 1, 8'h00);
        access(16'hFF07, 1, 0, 8'h00);
        access(16'hABCD, 1, 2, 8'h5A);
        access(16'h4000, 0, 1, 8'h00);
        access(16'h4001, 0, 2, 8'h11);
        access(16'h0055, 1, 3, 8'h00);
        access(16'h0066, 1, 4, 8'h77);

        for (int i = 0; i < 200; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom_range(1, 0) == 1) a[15:8] = 8'hFF;
            access(a, $urandom_range(3, 0) != 0, int'($urandom_range(4, 0)), 8'($urandom));
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule